// File: doc/BRIEF.md
# Command Stream Header Decoder

This block sits on a stream of 32-bit command words and splits it into headers and the data words that belong to them. A word that arrives while no data is outstanding is a header. It is decoded into one record: the opcode, the target register offset, the class, the mask, the number of data words that follow, an inline value, the gather flags and the lock operation with its index. Every word after a header, up to the expected count, is passed out as a data word. Each data word carries the register offset it targets, and the final data word of a header is flagged as last.

How many data words follow a header depends on the opcode. It can be the popcount of a mask field, a 16-bit count, a fixed one or two address words, or a length held in a sticky length register. That register is loaded by a length-load command and read by the wide sequential and wide fixed writes. After reset the length register is invalid. A wide write that arrives in that state consumes no data and raises a length-unknown flag. Unknown opcodes and unknown extended sub-operations are flagged.

Input and output both use a valid/ready handshake. The decoded record sits in a single output register, which is loaded on the edge that accepts a word.

Top module: `cmdhd_decoder`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, the length register is invalid, and the first accepted word is treated as a header.
- R2: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. The output record then holds unchanged, and the offered word is not consumed until `out_ready` returns to 1.
- R3: Opcode 0x0 (class select, opcode in bits 31:28) reports class = bits 15:6, offset = bits 27:16 and mask = bits 5:0. The count of following data words equals the number of set bits in that 6-bit mask.
- R4: Opcodes 0x1 (sequential) and 0x2 (fixed) report offset = bits 27:16 and count = bits 15:0, and a count of 0 means the next word is a header. The data words of 0x1 target offset, offset+1, offset+2 and so on. The data words of 0x2 all target offset.
- R5: Opcode 0x3 reports offset = bits 27:16 and mask = bits 15:0, and the count of following data words is the popcount of that mask. Its data words all target that offset.
- R6: Opcode 0x4 reports offset = bits 27:16 and value = bits 15:0. Opcode 0x5 reports value = the header shifted left by 4 (bits 27:0 followed by four zeros). Neither has data words.
- R7: Opcode 0x6 reports offset = bits 27:16, gather flags = {bit 15, bit 14} and value = bits 13:0, and exactly one data word follows. Opcode 0xC reports value = bits 13:0, and exactly two data words follow.
- R8: Opcode 0x7 reports value = bits 21:0. Opcode 0x8 reports value = bits 7:0. Opcode 0x9 reports value = bits 15:0 and loads that value into the length register, which marks it valid. The length register keeps its value across all other headers.
- R9: Opcodes 0xA (wide sequential) and 0xB (wide fixed) report offset = bits 21:0, and their count equals the length register. While the register is invalid the count is 0 and `out_len_unknown` is 1. A length of 0 also gives a count of 0. Data words of 0xA step the offset by one; data words of 0xB do not.
- R10: Opcode 0xE takes its sub-operation from bits 27:24. Sub-operation 0 reports lock_op = 01 and sub-operation 1 reports lock_op = 10, each with lock = bits 7:0. Any other sub-operation reports lock_op = 00 and `out_bad_ext` = 1. No data follows.
- R11: Opcodes 0xD and 0xF raise `out_bad_op` and have no data words.
- R12: A data word reports `out_is_data` = 1 and `out_word` = the input word, with all header fields 0 apart from the offset. `out_last` is 1 exactly on the data word that exhausts the count. The word after it is a header, whatever its bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word can be accepted |
| in_word | input | 32 | Command word |
| out_ready | input | 1 | Consumer takes the record |
| out_valid | output | 1 | Record valid |
| out_word | output | 32 | Raw word behind the record |
| out_is_hdr | output | 1 | Record is a header |
| out_is_data | output | 1 | Record is a data word |
| out_last | output | 1 | Final data word of its header |
| out_opcode | output | 4 | Header opcode (0 on data) |
| out_count | output | 16 | Data words that follow the header |
| out_offset | output | 22 | Register offset (header base or data target) |
| out_value | output | 32 | Inline value, address or count field |
| out_mask | output | 16 | Mask field |
| out_class | output | 10 | Class field |
| out_gflags | output | 2 | Gather insert/type flags |
| out_lock | output | 8 | Lock index |
| out_lock_op | output | 2 | 01 acquire, 10 release, 00 none |
| out_bad_op | output | 1 | Unknown opcode |
| out_bad_ext | output | 1 | Unknown extended sub-operation |
| out_len_unknown | output | 1 | Wide write seen with invalid length register |

## Verification
Two functions meet in adjacent accept cycles with no idle cycle between them.

The first pair is the data word that brings the count to zero and the header that follows it. The bench offers words back to back at full rate and checks two things: the last flag lands on the final data word, and the next word is decoded as a header even when its bits look like data.

The second pair is a length-load command followed at once by a wide write. The wide write must already read the freshly loaded length. The bench judges this by the header's count and by how many data words it then accepts before a header appears again.

// File: rtl/cmdhd_pkg.sv
package cmdhd_pkg;
  localparam int WORD_W = 32;
  localparam int OP_W   = 4;
  localparam int OFF_W  = 22;
  localparam int CNT_W  = 16;
  localparam int CLS_W  = 10;
  localparam int LOCK_W = 8;
  localparam int MSK_W  = 16;

  typedef enum logic [OP_W-1:0] {
    OP_CLASS   = 4'h0,
    OP_SEQ     = 4'h1,
    OP_FIXED   = 4'h2,
    OP_MASKED  = 4'h3,
    OP_INLINE  = 4'h4,
    OP_JUMP    = 4'h5,
    OP_FETCH   = 4'h6,
    OP_STREAM  = 4'h7,
    OP_APP     = 4'h8,
    OP_LOADLEN = 4'h9,
    OP_SEQ_W   = 4'hA,
    OP_FIXED_W = 4'hB,
    OP_FETCH_W = 4'hC,
    OP_RSV_D   = 4'hD,
    OP_EXT     = 4'hE,
    OP_RSV_F   = 4'hF
  } cmd_op_e;

  typedef struct packed {
    logic [CNT_W-1:0]  count;
    logic [OFF_W-1:0]  offset;
    logic [WORD_W-1:0] value;
    logic [MSK_W-1:0]  mask;
    logic [CLS_W-1:0]  cls;
    logic [1:0]        gflags;
    logic [LOCK_W-1:0] lock;
    logic [1:0]        lock_op;
    logic              bad_op;
    logic              bad_ext;
    logic              len_unknown;
    logic              step;
    logic              len_load;
  } hdr_rec_t;
endpackage

// File: rtl/cmdhd_popcount.sv
module cmdhd_popcount #(
  parameter int W = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] ones
);
  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + CW'(bits[i]);
    end
  end
endmodule

// File: rtl/cmdhd_hdr_decode.sv
module cmdhd_hdr_decode
  import cmdhd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              len_valid,
  input  logic [CNT_W-1:0]  len_val,
  output hdr_rec_t          rec
);
  localparam int CLSMSK_W = 6;
  localparam int PC6_W    = $clog2(CLSMSK_W + 1);
  localparam int PC16_W   = $clog2(MSK_W + 1);

  logic [PC6_W-1:0]  pc_cls;
  logic [PC16_W-1:0] pc_msk;
  cmd_op_e           op;

  cmdhd_popcount #(.W(CLSMSK_W)) u_pc_cls (.bits(word[CLSMSK_W-1:0]), .ones(pc_cls));
  cmdhd_popcount #(.W(MSK_W))    u_pc_msk (.bits(word[MSK_W-1:0]),    .ones(pc_msk));

  assign op = cmd_op_e'(word[31:28]);

  always_comb begin
    rec = '0;
    case (op)
      OP_CLASS: begin
        rec.cls    = word[15:6];
        rec.offset = OFF_W'(word[27:16]);
        rec.mask   = MSK_W'(word[5:0]);
        rec.count  = CNT_W'(pc_cls);
      end
      OP_SEQ: begin
        rec.offset = OFF_W'(word[27:16]);
        rec.count  = word[15:0];
        rec.step   = 1'b1;
      end
      OP_FIXED: begin
        rec.offset = OFF_W'(word[27:16]);
        rec.count  = word[15:0];
      end
      OP_MASKED: begin
        rec.offset = OFF_W'(word[27:16]);
        rec.mask   = word[15:0];
        rec.count  = CNT_W'(pc_msk);
      end
      OP_INLINE: begin
        rec.offset = OFF_W'(word[27:16]);
        rec.value  = WORD_W'(word[15:0]);
      end
      OP_JUMP: rec.value = {word[27:0], 4'h0};
      OP_FETCH: begin
        rec.offset = OFF_W'(word[27:16]);
        rec.gflags = word[15:14];
        rec.value  = WORD_W'(word[13:0]);
        rec.count  = CNT_W'(1);
      end
      OP_STREAM:  rec.value = WORD_W'(word[21:0]);
      OP_APP:     rec.value = WORD_W'(word[7:0]);
      OP_LOADLEN: begin
        rec.value    = WORD_W'(word[15:0]);
        rec.len_load = 1'b1;
      end
      OP_SEQ_W, OP_FIXED_W: begin
        rec.offset      = word[OFF_W-1:0];
        rec.count       = len_valid ? len_val : '0;
        rec.len_unknown = ~len_valid;
        rec.step        = (op == OP_SEQ_W);
      end
      OP_FETCH_W: begin
        rec.value = WORD_W'(word[13:0]);
        rec.count = CNT_W'(2);
      end
      OP_EXT: begin
        case (word[27:24])
          4'h0: begin
            rec.lock    = word[7:0];
            rec.lock_op = 2'b01;
          end
          4'h1: begin
            rec.lock    = word[7:0];
            rec.lock_op = 2'b10;
          end
          default: rec.bad_ext = 1'b1;
        endcase
      end
      default: rec.bad_op = 1'b1;
    endcase
  end
endmodule

// File: rtl/cmdhd_seq.sv
module cmdhd_seq
  import cmdhd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  hdr_rec_t         rec,
  output logic             hdr_phase,
  output logic [OFF_W-1:0] data_off,
  output logic             data_last,
  output logic             len_valid,
  output logic [CNT_W-1:0] len_val
);
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic             step_q, step_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic             lv_q, lv_d;

  assign hdr_phase = (rem_q == '0);
  assign data_last = (rem_q == CNT_W'(1));
  assign data_off  = off_q;
  assign len_valid = lv_q;
  assign len_val   = len_q;

  always_comb begin
    rem_d  = rem_q;
    off_d  = off_q;
    step_d = step_q;
    len_d  = len_q;
    lv_d   = lv_q;
    if (fire) begin
      if (hdr_phase) begin
        rem_d  = rec.count;
        off_d  = rec.offset;
        step_d = rec.step;
        if (rec.len_load) begin
          len_d = rec.value[CNT_W-1:0];
          lv_d  = 1'b1;
        end
      end else begin
        rem_d = rem_q - CNT_W'(1);
        if (step_q) off_d = off_q + OFF_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      off_q  <= '0;
      step_q <= 1'b0;
      len_q  <= '0;
      lv_q   <= 1'b0;
    end else if (fire) begin
      rem_q  <= rem_d;
      off_q  <= off_d;
      step_q <= step_d;
      len_q  <= len_d;
      lv_q   <= lv_d;
    end
  end
endmodule

// File: rtl/cmdhd_decoder.sv
module cmdhd_decoder
  import cmdhd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_is_hdr,
  output logic              out_is_data,
  output logic              out_last,
  output logic [OP_W-1:0]   out_opcode,
  output logic [CNT_W-1:0]  out_count,
  output logic [OFF_W-1:0]  out_offset,
  output logic [WORD_W-1:0] out_value,
  output logic [MSK_W-1:0]  out_mask,
  output logic [CLS_W-1:0]  out_class,
  output logic [1:0]        out_gflags,
  output logic [LOCK_W-1:0] out_lock,
  output logic [1:0]        out_lock_op,
  output logic              out_bad_op,
  output logic              out_bad_ext,
  output logic              out_len_unknown
);
  logic             fire;
  logic             hdr_phase;
  logic [OFF_W-1:0] data_off;
  logic             data_last;
  logic             len_valid;
  logic [CNT_W-1:0] len_val;
  hdr_rec_t         dec_rec;

  hdr_rec_t          rec_d, rec_q;
  logic              hdr_d, hdr_q, last_d, last_q;
  logic [OP_W-1:0]   op_d, op_q;
  logic [WORD_W-1:0] word_q;
  logic              valid_d, valid_q;

  assign in_ready = ~valid_q | out_ready;
  assign fire     = in_valid & in_ready;

  cmdhd_hdr_decode u_dec (
    .word      (in_word),
    .len_valid (len_valid),
    .len_val   (len_val),
    .rec       (dec_rec)
  );

  cmdhd_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .rec       (dec_rec),
    .hdr_phase (hdr_phase),
    .data_off  (data_off),
    .data_last (data_last),
    .len_valid (len_valid),
    .len_val   (len_val)
  );

  always_comb begin
    if (hdr_phase) begin
      rec_d  = dec_rec;
      hdr_d  = 1'b1;
      last_d = 1'b0;
      op_d   = in_word[31:28];
    end else begin
      rec_d        = '0;
      rec_d.offset = data_off;
      hdr_d        = 1'b0;
      last_d       = data_last;
      op_d         = '0;
    end
    if (fire)           valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
    else                valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q  <= '0;
      hdr_q  <= 1'b0;
      last_q <= 1'b0;
      op_q   <= '0;
      word_q <= '0;
    end else if (fire) begin
      rec_q  <= rec_d;
      hdr_q  <= hdr_d;
      last_q <= last_d;
      op_q   <= op_d;
      word_q <= in_word;
    end
  end

  assign out_valid       = valid_q;
  assign out_word        = word_q;
  assign out_is_hdr      = hdr_q;
  assign out_is_data     = ~hdr_q & valid_q;
  assign out_last        = last_q;
  assign out_opcode      = op_q;
  assign out_count       = rec_q.count;
  assign out_offset      = rec_q.offset;
  assign out_value       = rec_q.value;
  assign out_mask        = rec_q.mask;
  assign out_class       = rec_q.cls;
  assign out_gflags      = rec_q.gflags;
  assign out_lock        = rec_q.lock;
  assign out_lock_op     = rec_q.lock_op;
  assign out_bad_op      = rec_q.bad_op;
  assign out_bad_ext     = rec_q.bad_ext;
  assign out_len_unknown = rec_q.len_unknown;
endmodule

// File: rtl/cmdhd_decoder_chk.sv
module cmdhd_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_ready,
  input logic        out_valid,
  input logic [31:0] out_word,
  input logic        out_is_hdr,
  input logic        out_is_data,
  input logic        out_last,
  input logic [3:0]  out_opcode,
  input logic [15:0] out_count,
  input logic [15:0] out_mask,
  input logic [1:0]  out_lock_op,
  input logic        out_bad_op,
  input logic        out_bad_ext,
  input logic        out_len_unknown
);
  assert_kind_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({out_is_hdr, out_is_data}) == 1);

  assert_last_is_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> out_is_data);

  assert_hold_on_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_is_hdr) && $stable(out_count)));

  assert_no_take_on_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready || !out_valid);

  assert_class_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_hdr && out_opcode == 4'h0) |-> out_count == 16'($countones(out_mask[5:0])));

  assert_fetch_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_hdr && out_opcode == 4'h6) |-> out_count == 16'd1);

  assert_len_unknown_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len_unknown) |-> (out_count == 16'd0 && (out_opcode == 4'hA || out_opcode == 4'hB)));

  assert_ext_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_bad_ext) |-> (out_opcode == 4'hE && out_lock_op == 2'b00 && out_count == 16'd0));

  assert_bad_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_bad_op) |-> (out_is_hdr && out_count == 16'd0 && (out_opcode == 4'hD || out_opcode == 4'hF)));
endmodule

bind cmdhd_decoder cmdhd_decoder_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_ready        (in_ready),
  .out_ready       (out_ready),
  .out_valid       (out_valid),
  .out_word        (out_word),
  .out_is_hdr      (out_is_hdr),
  .out_is_data     (out_is_data),
  .out_last        (out_last),
  .out_opcode      (out_opcode),
  .out_count       (out_count),
  .out_mask        (out_mask),
  .out_lock_op     (out_lock_op),
  .out_bad_op      (out_bad_op),
  .out_bad_ext     (out_bad_ext),
  .out_len_unknown (out_len_unknown)
);

// File: tb/cmdhd_decoder_bench.sv
`timescale 1ns/1ps
module cmdhd_decoder_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_word;
  logic        out_ready;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_is_hdr, out_is_data, out_last;
  logic [3:0]  out_opcode;
  logic [15:0] out_count;
  logic [21:0] out_offset;
  logic [31:0] out_value;
  logic [15:0] out_mask;
  logic [9:0]  out_class;
  logic [1:0]  out_gflags;
  logic [7:0]  out_lock;
  logic [1:0]  out_lock_op;
  logic        out_bad_op, out_bad_ext, out_len_unknown;

  int n_run;
  int n_fail;
  bit done;

  int          m_rem;
  logic [21:0] m_off;
  bit          m_step;
  logic [15:0] m_len;
  bit          m_lv;

  cmdhd_decoder u_cmdhd_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_ready(out_ready), .out_valid(out_valid), .out_word(out_word),
    .out_is_hdr(out_is_hdr), .out_is_data(out_is_data), .out_last(out_last),
    .out_opcode(out_opcode), .out_count(out_count), .out_offset(out_offset),
    .out_value(out_value), .out_mask(out_mask), .out_class(out_class),
    .out_gflags(out_gflags), .out_lock(out_lock), .out_lock_op(out_lock_op),
    .out_bad_op(out_bad_op), .out_bad_ext(out_bad_ext), .out_len_unknown(out_len_unknown)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [149:0] act, input logic [149:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  function automatic logic [149:0] actual_sig();
    return {out_is_hdr, out_is_data, out_last, out_opcode, out_count, out_offset, out_value,
            out_mask, out_class, out_gflags, out_lock, out_lock_op, out_bad_op, out_bad_ext,
            out_len_unknown, out_word};
  endfunction

  // Compute the expected record from the requirements and advance the model.
  task automatic expect_word(input logic [31:0] w, output logic [149:0] e);
    logic [3:0]  op;
    logic [15:0] cnt, msk;
    logic [21:0] off;
    logic [31:0] val;
    logic [9:0]  cls;
    logic [1:0]  gf, lop;
    logic [7:0]  lk;
    logic        bo, be, lu, stp;
    if (m_rem == 0) begin
      op = w[31:28]; cnt = '0; msk = '0; off = '0; val = '0; cls = '0;
      gf = '0; lop = '0; lk = '0; bo = 0; be = 0; lu = 0; stp = 0;
      case (op)
        4'h0: begin cls = w[15:6]; off = 22'(w[27:16]); msk = 16'(w[5:0]); cnt = 16'($countones(w[5:0])); end
        4'h1: begin off = 22'(w[27:16]); cnt = w[15:0]; stp = 1; end
        4'h2: begin off = 22'(w[27:16]); cnt = w[15:0]; end
        4'h3: begin off = 22'(w[27:16]); msk = w[15:0]; cnt = 16'($countones(w[15:0])); end
        4'h4: begin off = 22'(w[27:16]); val = 32'(w[15:0]); end
        4'h5: val = w << 4;
        4'h6: begin off = 22'(w[27:16]); gf = {w[15], w[14]}; val = 32'(w[13:0]); cnt = 1; end
        4'h7: val = 32'(w[21:0]);
        4'h8: val = 32'(w[7:0]);
        4'h9: val = 32'(w[15:0]);
        4'hA, 4'hB: begin
          off = w[21:0]; stp = (op == 4'hA);
          if (m_lv) cnt = m_len; else lu = 1;
        end
        4'hC: begin val = 32'(w[13:0]); cnt = 2; end
        4'hE: begin
          if (w[27:24] == 4'h0) begin lop = 2'b01; lk = w[7:0]; end
          else if (w[27:24] == 4'h1) begin lop = 2'b10; lk = w[7:0]; end
          else be = 1;
        end
        default: bo = 1;
      endcase
      e = {1'b1, 1'b0, 1'b0, op, cnt, off, val, msk, cls, gf, lk, lop, bo, be, lu, w};
      m_rem = int'(cnt); m_off = off; m_step = stp;
      if (op == 4'h9) begin m_len = w[15:0]; m_lv = 1; end
    end else begin
      e = {1'b0, 1'b1, (m_rem == 1), 4'h0, 16'h0, m_off, 32'h0, 16'h0, 10'h0, 2'b0, 8'h0,
           2'b0, 1'b0, 1'b0, 1'b0, w};
      m_rem--;
      if (m_step) m_off = m_off + 22'd1;
    end
  endtask

  // Offer one word at full rate; called at a falling edge, returns at the next.
  task automatic send(input logic [31:0] w, input string tag);
    logic [149:0] e;
    expect_word(w, e);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    check(out_valid && (actual_sig() == e), tag, actual_sig(), e);
  endtask

  task automatic send_data(input int n, input string tag);
    for (int i = 0; i < n; i++) send(32'hD000_0000 ^ (i * 32'h0101_0013), tag);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    m_rem = 0; m_off = '0; m_step = 0; m_len = '0; m_lv = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R1 reset", {148'b0, out_valid, in_ready}, {148'b0, 2'b01});
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 after release", {148'b0, out_valid, in_ready}, {148'b0, 2'b01});

    // Wide write with the length register still invalid; next word is a header.
    send(32'hA012_3456, "R1 R9 unknown length");
    send(32'h4001_00AA, "R9 following header");

    // Class select: every 6-bit mask, each followed by its data words.
    for (int m = 0; m < 64; m++) begin
      send({4'h0, 12'h123, 10'h2A5, 6'(m)}, "R3");
      send_data($countones(6'(m)), "R12 R3 data");
    end

    // Sequential and fixed counts.
    for (int c = 0; c < 5; c++) begin
      send({4'h1, 12'hFFE, 16'(c)}, "R4 sequential");
      send_data(c, "R4 R12 sequential data");
    end
    send({4'h2, 12'h040, 16'd3}, "R4 fixed");
    send_data(3, "R4 fixed data");

    // Masked writes across patterns.
    for (int i = 0; i < 16; i++) begin
      send({4'h3, 12'h0AB, 16'(i * 16'h1111)}, "R5");
      send_data($countones(16'(i * 16'h1111)), "R5 data");
    end
    send({4'h3, 12'h7FF, 16'hA5C3}, "R5 mixed");
    send_data(8, "R5 mixed data");

    send(32'h4ABC_1234, "R6 inline");
    send(32'h5FED_CBA9, "R6 jump");
    send(32'h4000_0000, "R6 inline zero");

    // Gather flags, single and double address words.
    for (int f = 0; f < 4; f++) begin
      send({4'h6, 12'h321, 2'(f), 14'h2ABC}, "R7 fetch");
      send_data(1, "R7 fetch data");
    end
    send(32'hC000_3FFF, "R7 wide fetch");
    send_data(2, "R7 wide fetch data");

    send(32'h73FF_FFFF, "R8 stream");
    send(32'h8FFF_FF5A, "R8 app");
    send(32'h9000_0003, "R8 load length");
    send(32'hA03F_FFFE, "R9 wide sequential");
    send_data(3, "R9 wide sequential data");
    send(32'hB000_1000, "R9 wide fixed");
    send_data(3, "R9 wide fixed data");
    send(32'h9000_0002, "R8 reload length");
    send(32'h4001_0001, "R8 length kept across header");
    send(32'h7000_0001, "R8 length kept across header");
    send(32'hB000_0077, "R8 R9 length persists");
    send_data(2, "R9 data");
    send(32'h9000_0000, "R8 zero length");
    send(32'hA000_0005, "R9 zero length");
    send(32'h1000_0001, "R9 header after zero length");
    send_data(1, "R12");

    // Extended sub-operations.
    for (int s = 0; s < 16; s++) send({4'hE, 4'(s), 16'h0, 8'(s * 17 + 3)}, "R10");

    send(32'hD123_4567, "R11 opcode D");
    send(32'hF000_0000, "R11 opcode F");
    send(32'h2000_0001, "R12 fixed one");
    send(32'hF000_0000, "R12 data not decoded");
    idle();

    // Output stall: record must hold and input must wait.
    out_ready = 1'b0;
    in_valid = 1'b1; in_word = 32'h4011_1111;
    @(negedge clk);
    in_word = 32'h4022_2222;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid && !in_ready && out_word == 32'h4011_1111, "R2 stall hold",
            {116'b0, out_valid, in_ready, out_word}, {116'b0, 2'b10, 32'h4011_1111});
    end
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid && out_is_hdr && out_word == 32'h4022_2222, "R2 resume",
          {117'b0, out_is_hdr, out_word}, {117'b0, 1'b1, 32'h4022_2222});
    idle();
    check(!out_valid, "R2 drained", {149'b0, out_valid}, 150'b0);

    finish_run();
  end
endmodule